// File: doc/BRIEF.md
# Nonvolatile Write Guard for a 16K x 8 Serial Memory

This block sits between the serial command decoder of a 16K-byte serial memory and its cell array. It is the only path by which anything is written to nonvolatile storage. It keeps a write-enable latch and a small nonvolatile status image. That image holds a two-bit region lock code and a pin-honour flag. The block then decides, for every write sequence the front end hands it, whether the sequence may go on to a programming cycle.

The front end delivers already-decoded one-cycle strobes: latch set, latch clear, status write (with its byte) and data byte write (with address and byte). It also delivers the chip-select line and the count of bits modulo eight received in the current frame. Array bytes collect in a one-page buffer. When chip select rises on a legal sequence, a self-timed programming cycle begins, and it lasts a parameterized number of clocks. During that cycle the buffered bytes are handed to the array as commit strobes. A status write instead takes effect when the cycle ends. A status byte shows busy, the latch, the lock code and the pin-honour flag.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, busy is 0 and no commit strobe is issued.
- R2: A latch-set strobe while selected and idle sets status bit 1. A latch-clear strobe clears it. A write sequence started while the latch is 0 is ignored: no busy, no commit.
- R3: The lock code in status bits 3:2 protects no address (00), addresses 0x3000-0x3FFF (01), 0x2000-0x3FFF (10) or the whole array (11). A page sequence whose first address is locked is discarded with no busy and no commit, and the latch is cleared.
- R4: Byte k of a page sequence lands at offset (start offset + k) mod 32 within the 32-byte page of the first address. Later bytes to the same offset replace earlier ones. During the cycle each filled offset is committed once, one per clock, in ascending offset order.
- R5: An accepted status write copies bits 7, 3 and 2 of its byte into the status image when the cycle ends. The image does not change before that.
- R6: With the write-protect pin low and status bit 7 set, a status write is refused: no busy, image unchanged, latch cleared. With bit 7 clear, the pin level has no effect.
- R7: If the pin falls while chip select is still low after an accepted status write, that write is cancelled. A fall after the cycle has started does not stop it.
- R8: The cycle starts on the chip-select rise only if the bit count modulo eight is 0. Otherwise the sequence is refused and the latch is cleared.
- R9: Busy (status bit 0 and the busy output) stays high for exactly WRITE_CYCLES clocks. The latch reads 0 once it ends.
- R10: While busy, all four request strobes are ignored; status bits 7:1 hold their values until the cycle ends.
- R11: Status layout: bit 0 busy, bit 1 latch, bits 3:2 lock code, bit 7 pin-honour flag, bits 6:4 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| bit_phase | input | 3 | Frame bit count modulo eight |
| wren_req | input | 1 | Latch-set strobe |
| wrdi_req | input | 1 | Latch-clear strobe |
| wrsr_req | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Status write byte |
| wr_req | input | 1 | Array data byte strobe |
| wr_addr | input | ADDR_W | Byte address (first byte selects page and offset) |
| wr_data | input | 8 | Array data byte |
| status | output | 8 | Status byte |
| busy | output | 1 | Programming cycle in progress |
| commit_valid | output | 1 | Commit strobe to the array |
| commit_addr | output | ADDR_W | Address of committed byte |
| commit_data | output | 8 | Committed byte |

## Verification
The bench goes after the page wrap, where a design that adds without the modulo would commit into the next page. It also checks the commit order, where an out-of-order scan would show up. Lock-region edges such as 0x2FFF against 0x3000 are probed, since an off-by-one decode would either corrupt protected data or refuse legal writes. The bench drops the protect pin both before and after the cycle starts. A design that sampled the pin only once would apply a cancelled status write, and one that sampled it continuously would abort a started cycle. Strobes during busy and frames ending mid-byte are also driven; a wrong design would show a changed latch or a spurious cycle.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_ARRAY, OP_STATUS} op_kind_t;

  localparam int SR_BUSY  = 0;
  localparam int SR_WEL   = 1;
  localparam int SR_LOCK0 = 2;
  localparam int SR_FLAG  = 7;

  // region lock decode on the two top address bits
  function automatic logic region_locked(input logic [1:0] code, input logic [1:0] top2);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic bsy, input logic wel,
                                             input logic [1:0] code, input logic flag);
    logic [7:0] s;
    s = '0;
    s[SR_BUSY] = bsy;
    s[SR_WEL] = wel;
    s[SR_LOCK0 +: 2] = code;
    s[SR_FLAG] = flag;
    return s;
  endfunction

  function automatic logic [4:0] wrap_off(input logic [4:0] off, input int unsigned page);
    return 5'((int'(off) + 1) % page);
  endfunction
endpackage

// File: rtl/eewp_cycle_timer.sv
module eewp_cycle_timer #(
  parameter int CYCLES = 100,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  assign done = busy && (count == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      count <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (busy) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/eewp_page_buf.sv
module eewp_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              first,
  input  logic [OFF_W-1:0]  load_off,
  input  logic [DATA_W-1:0] load_data,
  input  logic [OFF_W-1:0]  scan_off,
  output logic              scan_hit,
  output logic [DATA_W-1:0] scan_data
);
  logic [PAGE_BYTES-1:0] fill_q;
  logic [DATA_W-1:0]     bytes_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fill_q[g]  <= 1'b0;
        bytes_q[g] <= '0;
      end else if (load) begin
        if (load_off == OFF_W'(g)) begin
          fill_q[g]  <= 1'b1;
          bytes_q[g] <= load_data;
        end else if (first) begin
          fill_q[g] <= 1'b0;
        end
      end
    end
  end

  assign scan_hit  = fill_q[scan_off];
  assign scan_data = bytes_q[scan_off];
endmodule

// File: rtl/eewp_guard.sv
module eewp_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       apply_sr,
  input  logic [7:0] sr_data,
  output logic       wel,
  output logic [1:0] lock_code,
  output logic       pin_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      lock_code <= 2'b00;
      pin_flag  <= 1'b0;
    end else begin
      if (clr_wel)      wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
      if (apply_sr) begin
        lock_code <= sr_data[eewp_pkg::SR_LOCK0 +: 2];
        pin_flag  <= sr_data[eewp_pkg::SR_FLAG];
      end
    end
  end
endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl #(
  parameter int ADDR_W = 14,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W = 8,
  parameter int WRITE_CYCLES = 100,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic [2:0]        bit_phase,
  input  logic              wren_req,
  input  logic              wrdi_req,
  input  logic              wrsr_req,
  input  logic [7:0]        wrsr_data,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        status,
  output logic              busy,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import eewp_pkg::*;

  logic             cs_q_n;
  op_kind_t         pend_kind, cyc_kind;
  logic             pend_bad;
  logic [7:0]       pend_sr;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0] off_q;
  logic             wel, pin_flag;
  logic [1:0]       lock_code;
  logic [CNT_W-1:0] cyc_count;
  logic             buf_hit;
  logic [DATA_W-1:0] buf_data;

  // named internal events
  logic cs_rise, accept_ok, wp_block, seq_start_array, seq_start_status;
  logic status_cancel, cycle_start, cycle_done, seq_refuse, buf_load, in_scan;
  logic [OFF_W-1:0] load_off, scan_off;

  assign cs_rise          = !cs_q_n && cs_n;
  assign accept_ok        = !busy && !cs_n;
  assign wp_block         = !wp_n && pin_flag;
  assign seq_start_array  = accept_ok && wr_req && (pend_kind == OP_NONE) && wel;
  assign seq_start_status = accept_ok && wrsr_req && !wr_req && (pend_kind == OP_NONE) && wel;
  assign status_cancel    = (pend_kind == OP_STATUS) && wp_block && !cs_n;
  assign cycle_start      = cs_rise && (pend_kind != OP_NONE) && !pend_bad && (bit_phase == 3'd0);
  assign seq_refuse       = cs_rise && (pend_kind != OP_NONE) && !cycle_start;
  assign buf_load         = accept_ok && wr_req && (seq_start_array || pend_kind == OP_ARRAY);
  assign load_off         = seq_start_array ? wr_addr[OFF_W-1:0] : off_q;
  assign in_scan          = int'(cyc_count) < PAGE_BYTES;
  assign scan_off         = cyc_count[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q_n <= 1'b1;
    else        cs_q_n <= cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_kind <= OP_NONE;
      pend_bad  <= 1'b0;
      pend_sr   <= '0;
      page_q    <= '0;
      off_q     <= '0;
      cyc_kind  <= OP_NONE;
    end else begin
      if (cs_rise) begin
        pend_kind <= OP_NONE;
        pend_bad  <= 1'b0;
        if (cycle_start) cyc_kind <= pend_kind;
      end else if (seq_start_array) begin
        pend_kind <= OP_ARRAY;
        pend_bad  <= region_locked(lock_code, wr_addr[ADDR_W-1 -: 2]);
        page_q    <= wr_addr[ADDR_W-1:OFF_W];
        off_q     <= wrap_off(wr_addr[OFF_W-1:0], PAGE_BYTES);
      end else if (seq_start_status) begin
        pend_kind <= OP_STATUS;
        pend_bad  <= wp_block;
        pend_sr   <= wrsr_data;
      end else if (pend_kind != OP_NONE) begin
        if (status_cancel) pend_bad <= 1'b1;
        if (accept_ok && wrdi_req) pend_bad <= 1'b1;
        if (accept_ok && wrsr_req && pend_kind == OP_ARRAY) pend_bad <= 1'b1;
        if (accept_ok && wr_req && pend_kind == OP_STATUS) pend_bad <= 1'b1;
        if (buf_load) off_q <= wrap_off(off_q, PAGE_BYTES);
      end
    end
  end

  eewp_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cycle_start),
    .busy  (busy),
    .count (cyc_count),
    .done  (cycle_done)
  );

  eewp_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (buf_load),
    .first     (seq_start_array),
    .load_off  (load_off),
    .load_data (wr_data),
    .scan_off  (scan_off),
    .scan_hit  (buf_hit),
    .scan_data (buf_data)
  );

  eewp_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_wel   (accept_ok && wren_req),
    .clr_wel   ((accept_ok && wrdi_req) || seq_refuse || cycle_done),
    .apply_sr  (cycle_done && cyc_kind == OP_STATUS),
    .sr_data   (pend_sr),
    .wel       (wel),
    .lock_code (lock_code),
    .pin_flag  (pin_flag)
  );

  assign status       = pack_status(busy, wel, lock_code, pin_flag);
  assign commit_valid = busy && (cyc_kind == OP_ARRAY) && in_scan && buf_hit;
  assign commit_addr  = {page_q, scan_off};
  assign commit_data  = buf_data;
endmodule

// File: rtl/eewp_checker.sv
module eewp_checker #(
  parameter int ADDR_W = 14,
  parameter int WRITE_CYCLES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic [2:0]        bit_phase,
  input logic [7:0]        status,
  input logic              busy,
  input logic              commit_valid,
  input logic [ADDR_W-1:0] commit_addr,
  input logic              cycle_start
);
  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_COMMIT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> busy); // R9
  AST_COMMIT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !eewp_pkg::region_locked(status[3:2], commit_addr[ADDR_W-1 -: 2])); // R3
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> status[1]); // R2
  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bit_phase) == 3'd0)); // R8
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]); // R9
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == WRITE_CYCLES)); // R9
  AST_BUSY_FREEZES_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[7:1])); // R10
  AST_PIN_LOCKS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7] && !busy && $past(!busy)) |-> $stable(status[7:2])); // R6
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000); // R11
endmodule

bind eeprom_wprot_ctrl eewp_checker #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_n         (wp_n),
  .bit_phase    (bit_phase),
  .status       (status),
  .busy         (busy),
  .commit_valid (commit_valid),
  .commit_addr  (commit_addr),
  .cycle_start  (cycle_start)
);

// File: tb/eeprom_wprot_ctrl_tb.sv
module eeprom_wprot_ctrl_tb;
  localparam int AW = 14;
  localparam int PG = 32;
  localparam int WC = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1;
  logic [2:0] bit_phase = 3'd0;
  logic wren_req = 0, wrdi_req = 0, wrsr_req = 0, wr_req = 0;
  logic [7:0] wrsr_data = 0, wr_data = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [7:0] status;
  logic busy, commit_valid;
  logic [AW-1:0] commit_addr;
  logic [7:0] commit_data;

  always #2.5 clk = ~clk;

  eeprom_wprot_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .bit_phase(bit_phase),
    .wren_req(wren_req), .wrdi_req(wrdi_req), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .status(status), .busy(busy),
    .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data));

  int total = 0, bad = 0;
  logic [PG-1:0] exp_mask;
  logic [7:0] exp_data [PG];
  int exp_page = 0, last_off = -1, ncommit = 0, busy_run = 0, last_run = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // commit monitor: R4 page, data, ascending order
  always @(negedge clk) begin
    if (rst_n && commit_valid) begin
      int off;
      off = int'(commit_addr) % PG;
      ncommit++;
      chk((int'(commit_addr) / PG) == exp_page && exp_mask[off] &&
          commit_data == exp_data[off] && off > last_off, "R4 commit", int'(commit_addr), exp_page * PG + off);
      last_off = off;
    end
    if (busy) busy_run++;
    else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
  end

  // bench restatement of the lock regions: lowest locked address per code
  function automatic bit locked(input int code, input int addr);
    int lim;
    lim = (code == 0) ? 16384 : (code == 1) ? 12288 : (code == 2) ? 8192 : 0;
    return addr >= lim;
  endfunction

  function automatic int popc(input logic [PG-1:0] m);
    int n = 0;
    for (int i = 0; i < PG; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic cs_lo(); cs_n = 0; tick(); endtask
  task automatic cs_hi(); cs_n = 1; tick(); endtask
  task automatic pulse_wren(); wren_req = 1; tick(); wren_req = 0; endtask
  task automatic pulse_wrdi(); wrdi_req = 1; tick(); wrdi_req = 0; endtask
  task automatic pulse_wrsr(input logic [7:0] d);
    wrsr_data = d; wrsr_req = 1; tick(); wrsr_req = 0;
  endtask
  task automatic pulse_wr(input int a, input logic [7:0] d);
    wr_addr = AW'(a); wr_data = d; wr_req = 1; tick(); wr_req = 0;
  endtask
  task automatic wait_idle();
    int g = 0;
    while (busy && g < 1000) begin tick(); g++; end
    tick();
  endtask
  task automatic enable_frame(); cs_lo(); pulse_wren(); cs_hi(); endtask

  task automatic set_sr(input logic [7:0] d);
    enable_frame(); cs_lo(); pulse_wrsr(d); cs_hi(); wait_idle();
  endtask

  // page write; go = expected start of a cycle
  task automatic page_write(input int a, input int n, input bit go, input string req);
    exp_mask = '0; exp_page = a / PG; last_off = -1; ncommit = 0;
    enable_frame();
    cs_lo();
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      int off;
      d = 8'($urandom);
      off = (a % PG + i) % PG;
      if (go) begin exp_mask[off] = 1'b1; exp_data[off] = d; end
      pulse_wr(a, d);
    end
    cs_hi();
    chk(busy == go, req, int'(busy), int'(go));
    wait_idle();
    chk(ncommit == popc(exp_mask), req, ncommit, popc(exp_mask));
    chk(status[1] == 1'b0, req, int'(status), 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        chk(0, "watchdog", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_mask = '0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 R11 reset image
    chk(status == 8'h00 && !busy, "R1", int'(status), 0);
    // R2 latch set / clear
    cs_lo(); pulse_wren();
    chk(status == 8'h02, "R2 R11 latch set", int'(status), 2);
    pulse_wrdi();
    chk(status == 8'h00, "R2 latch clear", int'(status), 0);
    cs_hi();
    // R2 write without latch ignored
    cs_lo(); pulse_wr(40, 8'hAA); cs_hi();
    chk(!busy, "R2 no latch", int'(busy), 0);
    wait_idle();
    chk(ncommit == 0, "R2 no commit", ncommit, 0);
    // R4 R9 basic page write and busy length
    page_write(64, 3, 1, "R4 basic");
    chk(last_run == WC, "R9 busy length", last_run, WC);
    // R4 wrap within page
    page_write(32 * 5 + 30, 5, 1, "R4 wrap");
    // R4 overwrite same offset (34 bytes from offset 0)
    page_write(32 * 7, 34, 1, "R4 overwrite");
    // R5 status write applied only at end
    enable_frame(); cs_lo(); pulse_wrsr(8'h04); cs_hi();
    repeat (10) tick();
    chk(status == 8'h03, "R5 mid cycle", int'(status), 3);
    wait_idle();
    chk(status == 8'h04, "R5 applied", int'(status), 4);
    // R3 lock boundaries
    page_write(12288, 2, 0, "R3 quarter locked");
    page_write(12287 - 31, 4, 1, "R3 below quarter");
    set_sr(8'h08);
    page_write(8192, 1, 0, "R3 half locked");
    page_write(8191, 1, 1, "R3 below half");
    set_sr(8'h0C);
    page_write(0, 1, 0, "R3 all locked");
    set_sr(8'h00);
    // R8 misaligned end
    enable_frame(); cs_lo(); pulse_wr(96, 8'h11); bit_phase = 3'd3; cs_hi(); bit_phase = 3'd0;
    chk(!busy && status[1] == 0, "R8 misaligned", int'(status), 0);
    // R10 strobes during busy ignored
    exp_mask = '0; exp_page = 4; last_off = -1; ncommit = 0;
    enable_frame(); cs_lo(); exp_mask[1] = 1; exp_data[1] = 8'h5A; pulse_wr(129, 8'h5A); cs_hi();
    repeat (5) tick();
    cs_lo(); pulse_wrdi(); pulse_wr(130, 8'hFF); pulse_wrsr(8'h8C); cs_hi();
    chk(status == 8'h03, "R10 busy ignores", int'(status), 3);
    wait_idle();
    chk(ncommit == 1 && status == 8'h00, "R10 after", ncommit, 1);
    // R6 flag set then pin low refuses
    set_sr(8'h80);
    chk(status == 8'h80, "R6 flag set", int'(status), 8'h80);
    wp_n = 0;
    enable_frame(); cs_lo(); pulse_wrsr(8'h0C); cs_hi();
    chk(!busy && status == 8'h80, "R6 refused", int'(status), 8'h80);
    // R7 pin falls while selected cancels
    wp_n = 1;
    enable_frame(); cs_lo(); pulse_wrsr(8'h84); wp_n = 0; tick(); cs_hi();
    chk(!busy && status == 8'h80, "R7 cancelled", int'(status), 8'h80);
    // R7 pin falls after cycle start: no effect
    wp_n = 1;
    enable_frame(); cs_lo(); pulse_wrsr(8'h88); cs_hi();
    wp_n = 0; wait_idle();
    chk(status == 8'h88, "R7 started", int'(status), 8'h88);
    wp_n = 1; set_sr(8'h00);
    // R6 flag clear: pin ignored
    wp_n = 0;
    set_sr(8'h04);
    chk(status == 8'h04, "R6 pin ignored", int'(status), 4);
    set_sr(8'h00);
    wp_n = 1;
    // R3 R4 random page writes under random lock codes
    for (int it = 0; it < 30; it++) begin
      int code, a, n;
      code = int'($urandom % 4);
      set_sr(8'(code << 2));
      chk(status == 8'(code << 2), "R5 random", int'(status), code << 2);
      a = int'($urandom % 16384);
      n = 1 + int'($urandom % 40);
      page_write(a, n, !locked(code, a), "R3 R4 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule